// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

The controller sits beside a small processor core and decides, once per instruction, whether an interrupt is taken and which one. It watches five sources. The first is a non-maskable trap. Three are restart lines, each with a fixed service address. The last is a general request whose service opcode is supplied from outside the core. Sources are considered only in the clock cycle that the core marks with its "instruction nearly done" strobe.

A global enable and three per-restart mask bits gate the maskable sources. Software controls the global enable through set and clear pulses, and writes the masks through a small mask-write port. When a maskable source is accepted, the global enable drops by itself. When the general request wins, the controller first asks the core to hold its program counter. On the following cycle it raises an acknowledge, timed like a read, so that an external device can place a restart or call opcode on the bus. When a restart source or the trap wins, the controller gives the core a 16-bit service address and no external opcode is needed.

Top module: `irq_ctrl`

## Requirements
- R1: Among the sources that are requesting, the one taken follows a fixed order, highest first: trap, restart-7.5, restart-6.5, restart-5.5, general request. Their vectors are 0x0024, 0x003C, 0x0034 and 0x002C. The general request reports vector 0x0000.
- R2: The trap is taken whatever the global enable and the mask bits hold.
- R3: Sources are judged only on a clock edge where `sample_i` is high. `take_o` and `vector_o` are registered from that edge and stay high for one cycle. At every other time they are 0.
- R4: When the general request is accepted, `pc_hold_o` pulses together with `take_o`, and `inta_o` pulses for one cycle on the cycle after.
- R5: A mask write sets the mask bits from `mask_wdata_i`: bit 2 masks restart-7.5, bit 1 masks restart-6.5 and bit 0 masks restart-5.5, where 1 means masked. Reset sets all three mask bits. The mask bits do not affect the general request.
- R6: Restart-7.5 latches a pending bit on a rising edge. The bit is kept while that source is masked. It is cleared when that source is accepted, or by a mask write with `mask_wdata_i[3]`=1.
- R7: Restart-6.5, restart-5.5 and the general request are level sensitive. If one of them drops before the sample edge, it is not taken.
- R8: The trap is recognised only after a rising edge when the line is still high at the sample edge. If the line falls first, the trap is cancelled. A trap that has been serviced is not taken again until a new rising edge.
- R9: Reset clears the global enable. `ie_set_i` sets it and `ie_clr_i` clears it; when both are high, clear wins. Accepting a maskable source clears it. Accepting the trap leaves it unchanged.
- R10: During reset and right after it, `take_o`, `pc_hold_o`, `inta_o` and `vector_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Non-maskable trap line |
| rst75_i | input | 1 | Edge-triggered restart line, highest maskable |
| rst65_i | input | 1 | Level restart line |
| rst55_i | input | 1 | Level restart line, lowest restart |
| intr_i | input | 1 | General interrupt request, level |
| sample_i | input | 1 | Core strobe for the next-to-last cycle of an instruction |
| ie_set_i | input | 1 | Software pulse that enables interrupts |
| ie_clr_i | input | 1 | Software pulse that disables interrupts |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 4 | [2:0] mask bits for 7.5/6.5/5.5, [3] clears the 7.5 pending bit |
| take_o | output | 1 | Interrupt taken, one-cycle pulse |
| vector_o | output | 16 | Service address of the taken source |
| pc_hold_o | output | 1 | Hold the program counter (general request) |
| inta_o | output | 1 | Acknowledge for the general request, one cycle after the hold |

## Verification
On every cycle, the assertions check that at most one source is granted. They also check that a take is only ever registered from a sampled edge, that each acknowledge follows a PC hold, and that the global enable is low after any maskable take. Finally they check that the 7.5 pending bit only rises after a rising edge on its line. Other behaviours need a sequence of events, and only the bench's scenarios show them: the full priority order under various mask and enable settings, a trap cancelled by an early fall, a pending 7.5 held while masked and released later, and the mask-write clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned VEC_W   = 16;
  localparam int unsigned NUM_RST = 3;
  localparam int unsigned MWD_W   = NUM_RST + 1;

  // source index doubles as priority rank, 0 highest
  typedef enum logic [2:0] {
    SRC_TRAP = 3'd0,
    SRC_R75  = 3'd1,
    SRC_R65  = 3'd2,
    SRC_R55  = 3'd3,
    SRC_INTR = 3'd4
  } src_e;

  localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_R75  = 16'h003C;
  localparam logic [VEC_W-1:0] VEC_R65  = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_R55  = 16'h002C;

  function automatic logic [VEC_W-1:0] src_vector(input int unsigned idx);
    case (idx)
      SRC_TRAP: return VEC_TRAP;
      SRC_R75:  return VEC_R75;
      SRC_R65:  return VEC_R65;
      SRC_R55:  return VEC_R55;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter bit HOLD_LEVEL = 1'b0  // 1: request also needs the line still high
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic clr_i,
  output logic req_o
);
  logic prev_q, pend_q, pend_d, edge_w;

  assign edge_w = lvl_i & ~prev_q;

  generate
    if (HOLD_LEVEL) begin : g_hold
      always_comb begin
        if (edge_w)     pend_d = 1'b1;
        else if (clr_i) pend_d = 1'b0;
        else            pend_d = pend_q & lvl_i;
      end
      assign req_o = pend_q & lvl_i;
    end else begin : g_sticky
      always_comb begin
        if (edge_w)     pend_d = 1'b1;
        else if (clr_i) pend_d = 1'b0;
        else            pend_d = pend_q;
      end
      assign req_o = pend_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= pend_d;
    end
  end

  p_pend_needs_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(lvl_i & ~prev_q));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int unsigned N = irq_pkg::NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  // bit 0 is highest priority
  generate
    for (genvar i = 0; i < N; i++) begin : g_grant
      if (i == 0) begin : g_top
        assign grant_o[i] = req_i[i];
      end else begin : g_rest
        assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
      end
    end
  endgenerate

  assign any_o = |req_i;

  p_grant_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  p_grant_when_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|grant_o));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_i,
  input  logic             rst75_i,
  input  logic             rst65_i,
  input  logic             rst55_i,
  input  logic             intr_i,
  input  logic             sample_i,
  input  logic             ie_set_i,
  input  logic             ie_clr_i,
  input  logic             mask_we_i,
  input  logic [MWD_W-1:0] mask_wdata_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             pc_hold_o,
  output logic             inta_o
);
  localparam int unsigned MSK_R75 = 2;
  localparam int unsigned MSK_R65 = 1;
  localparam int unsigned MSK_R55 = 0;
  localparam int unsigned CLR_R75 = NUM_RST;

  logic [NUM_RST-1:0] mask_q;
  logic               ie_q, ie_d;
  logic               trap_req, r75_pend;
  logic [NUM_SRC-1:0] req, grant;
  logic               any_req, accept, accept_mask;
  logic [VEC_W-1:0]   vec_sel;
  logic               clr_trap, clr_r75;

  irq_edge_latch #(.HOLD_LEVEL(1'b1)) u_trap (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(trap_i),
    .clr_i (clr_trap), .req_o(trap_req)
  );

  irq_edge_latch #(.HOLD_LEVEL(1'b0)) u_r75 (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(rst75_i),
    .clr_i (clr_r75), .req_o(r75_pend)
  );

  always_comb begin
    req           = '0;
    req[SRC_TRAP] = trap_req;
    req[SRC_R75]  = r75_pend & ~mask_q[MSK_R75] & ie_q;
    req[SRC_R65]  = rst65_i  & ~mask_q[MSK_R65] & ie_q;
    req[SRC_R55]  = rst55_i  & ~mask_q[MSK_R55] & ie_q;
    req[SRC_INTR] = intr_i & ie_q;
  end

  irq_prio_arb #(.N(NUM_SRC)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req),
    .grant_o(grant), .any_o(any_req)
  );

  assign accept      = sample_i & any_req;
  assign accept_mask = accept & ~grant[SRC_TRAP];
  assign clr_trap    = accept & grant[SRC_TRAP];
  assign clr_r75     = (accept & grant[SRC_R75]) | (mask_we_i & mask_wdata_i[CLR_R75]);

  always_comb begin
    vec_sel = '0;
    for (int unsigned i = 0; i < NUM_SRC; i++)
      if (grant[i]) vec_sel = src_vector(i);
  end

  // acceptance beats software, clear beats set
  always_comb begin
    if (accept_mask)   ie_d = 1'b0;
    else if (ie_clr_i) ie_d = 1'b0;
    else if (ie_set_i) ie_d = 1'b1;
    else               ie_d = ie_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '1;
      ie_q      <= 1'b0;
      take_o    <= 1'b0;
      vector_o  <= '0;
      pc_hold_o <= 1'b0;
      inta_o    <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i[NUM_RST-1:0];
      ie_q      <= ie_d;
      take_o    <= accept;
      vector_o  <= accept ? vec_sel : '0;
      pc_hold_o <= accept & grant[SRC_INTR];
      inta_o    <= pc_hold_o;
    end
  end

  p_take_on_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(sample_i));
  p_inta_after_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |-> $past(pc_hold_o));
  p_hold_is_intr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_hold_o |-> (take_o && vector_o == '0));
  p_ie_off_after_take_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vector_o != VEC_TRAP) |-> !ie_q);
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        trap_i, rst75_i, rst65_i, rst55_i, intr_i;
  logic        sample_i, ie_set_i, ie_clr_i, mask_we_i;
  logic [3:0]  mask_wdata_i;
  logic        take_o, pc_hold_o, inta_o;
  logic [15:0] vector_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  irq_ctrl dut (.*);

  // {ie, mask[2:0], trap, r75, r65, r55, intr, take, inta, vec[15:0]}
  localparam int NV = 12;
  localparam logic [26:0] VECS [NV] = '{
    {1'b1, 3'b000, 5'b11111, 1'b1, 1'b0, 16'h0024},
    {1'b1, 3'b000, 5'b01111, 1'b1, 1'b0, 16'h003C},
    {1'b1, 3'b000, 5'b00111, 1'b1, 1'b0, 16'h0034},
    {1'b1, 3'b000, 5'b00011, 1'b1, 1'b0, 16'h002C},
    {1'b1, 3'b000, 5'b00001, 1'b1, 1'b1, 16'h0000},
    {1'b0, 3'b000, 5'b01111, 1'b0, 1'b0, 16'h0000},
    {1'b0, 3'b111, 5'b11111, 1'b1, 1'b0, 16'h0024},
    {1'b1, 3'b111, 5'b01111, 1'b1, 1'b1, 16'h0000},
    {1'b1, 3'b100, 5'b01110, 1'b1, 1'b0, 16'h0034},
    {1'b1, 3'b011, 5'b00110, 1'b0, 1'b0, 16'h0000},
    {1'b1, 3'b010, 5'b00110, 1'b1, 1'b0, 16'h002C},
    {1'b1, 3'b000, 5'b00000, 1'b0, 1'b0, 16'h0000}
  };

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    {trap_i, rst75_i, rst65_i, rst55_i, intr_i} = '0;
    {sample_i, ie_set_i, ie_clr_i, mask_we_i} = '0;
    mask_wdata_i = '0;
    rst_ni = 1'b0;
    tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic mask_wr(input logic [3:0] d);
    mask_we_i = 1'b1; mask_wdata_i = d;
    tick();
    mask_we_i = 1'b0; mask_wdata_i = '0;
  endtask

  task automatic ie_on();
    ie_set_i = 1'b1;
    tick();
    ie_set_i = 1'b0;
  endtask

  // pulse sample, check registered take and vector
  task automatic samp(input string tag, input logic exp_take, input logic [15:0] exp_vec);
    sample_i = 1'b1;
    tick();
    sample_i = 1'b0;
    chk({tag, " take"}, take_o, exp_take);
    chk({tag, " vec"}, vector_o, exp_vec);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R10 reset state
    {trap_i, rst75_i, rst65_i, rst55_i, intr_i} = '0;
    {sample_i, ie_set_i, ie_clr_i, mask_we_i} = '0;
    mask_wdata_i = '0;
    rst_ni = 1'b0;
    #1;
    chk("R10 take in reset", take_o, 0);
    chk("R10 vec in reset", vector_o, 0);
    chk("R10 inta in reset", {pc_hold_o, inta_o}, 0);
    do_reset();
    chk("R10 take after reset", take_o, 0);

    // R1 R2 R5 R7: table walk
    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VECS[i];
      do_reset();
      mask_wr({1'b0, v[25:23]});
      if (v[26]) ie_on();
      {trap_i, rst75_i, rst65_i, rst55_i, intr_i} = v[22:18];
      tick();
      samp($sformatf("R1 vec%0d", i), v[17], v[15:0]);
      chk($sformatf("R4 hold vec%0d", i), pc_hold_o, v[16]);
      tick();
      chk($sformatf("R4 inta vec%0d", i), inta_o, v[16]);
      chk($sformatf("R3 take one cycle vec%0d", i), take_o, 0);
    end

    // R5 reset masks all restarts
    do_reset();
    ie_on();
    rst55_i = 1'b1;
    samp("R5 reset mask", 0, 16'h0);

    // R3 no strobe, no take
    do_reset();
    mask_wr(4'b0000);
    ie_on();
    rst65_i = 1'b1;
    tick(); tick();
    chk("R3 no strobe", take_o, 0);
    samp("R3 strobe", 1, 16'h0034);

    // R9 enable dropped after acceptance, clear wins over set
    samp("R9 ie cleared by accept", 0, 16'h0);
    ie_set_i = 1'b1; ie_clr_i = 1'b1;
    tick();
    ie_set_i = 1'b0; ie_clr_i = 1'b0;
    samp("R9 clear beats set", 0, 16'h0);
    ie_on();
    ie_clr_i = 1'b1;
    tick();
    ie_clr_i = 1'b0;
    samp("R9 ie_clr", 0, 16'h0);
    rst65_i = 1'b0;

    // R9 trap leaves enable intact
    do_reset();
    mask_wr(4'b0000);
    ie_on();
    trap_i = 1'b1;
    tick();
    samp("R9 trap taken", 1, 16'h0024);
    trap_i = 1'b0;
    intr_i = 1'b1;
    samp("R9 ie kept after trap", 1, 16'h0000);
    intr_i = 1'b0;

    // R7 level drop before sample
    do_reset();
    mask_wr(4'b0000);
    ie_on();
    intr_i = 1'b1;
    tick();
    intr_i = 1'b0;
    samp("R7 intr dropped", 0, 16'h0);

    // R8 trap cancelled by early fall; no retake without new edge
    do_reset();
    trap_i = 1'b1;
    tick();
    trap_i = 1'b0;
    tick();
    trap_i = 1'b1;
    samp("R8 trap cancelled then new edge", 0, 16'h0);
    samp("R8 trap new edge", 1, 16'h0024);
    samp("R8 trap serviced", 0, 16'h0);
    trap_i = 1'b0;

    // R6 pending held while masked, released on unmask, cleared on take
    do_reset();
    mask_wr(4'b0100);
    ie_on();
    rst75_i = 1'b1;
    tick();
    rst75_i = 1'b0;
    samp("R6 masked pending", 0, 16'h0);
    mask_wr(4'b0000);
    samp("R6 unmasked pending", 1, 16'h003C);
    ie_on();
    samp("R6 cleared by take", 0, 16'h0);

    // R6 mask-write clear bit
    rst75_i = 1'b1;
    tick();
    rst75_i = 1'b0;
    mask_wr(4'b1000);
    samp("R6 cleared by mask write", 0, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule